// File: doc/BRIEF.md
# Masked Data Breakpoint Unit

This unit watches the data accesses of a processor pipeline and raises a hit before a load or store is allowed to complete. It holds a small set of breakpoints. Each breakpoint has a 32-bit watch address and a 32-bit control word. The control word arms the breakpoint for loads, for stores, or for both. It also carries a 6-bit mask field that widens the match from a single byte to an aligned block of up to 64 bytes.

Software, or a debug agent, programs the breakpoints through a one-cycle register write port. The pipeline presents every access on the access port: its address, whether it is a store, and a valid strobe. The unit answers in the same cycle with a hit flag and the index of the matching breakpoint, so the access can be held back. A mask field that does not describe a contiguous aligned block is cut back to its leading run of ones before it is used. The unit therefore always watches a power-of-two aligned region.

Top module: `dbk_unit`

## Requirements
- R1: After reset every breakpoint is disarmed: no access of any kind produces a hit until a control word with an enable bit has been written.
- R2: A write with `cfg_sel_ctrl`=1 loads the control word of breakpoint `cfg_idx`, and a write with `cfg_sel_ctrl`=0 loads its watch address. The new value governs matching from the cycle after the write. In the control word, bit 31 is store-enable, bit 30 is load-enable and bits [5:0] are the mask field. Every other control bit has no effect on matching.
- R3: A breakpoint with only store-enable set hits on stores and never on loads. One with only load-enable set hits on loads and never on stores. One with both bits clear never hits.
- R4: The effective mask is the mask field with ones in every address bit above bit 5. An access matches when (access address AND mask) equals (watch address AND mask). For example, field 6'b111000 watches the 8-byte aligned block that holds the watch address.
- R5: A mask field that is not a run of ones from bit 5 downward followed by zeros is reduced to that leading run. For example, 6'b110100 acts as 6'b110000, which watches 16 bytes, and 6'b011111 acts as 6'b000000, which watches 64 bytes.
- R6: `hit` is combinational in the cycle the access is presented and is qualified by `acc_valid`. With `acc_valid` low, `hit` is 0.
- R7: When several breakpoints match, `hit_idx` reports the lowest index. When there is no hit, `hit_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel_ctrl | input | 1 | 1 selects the control word, 0 selects the watch address |
| cfg_idx | input | IDX_W | Breakpoint index of the write |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| hit | output | 1 | The access matches an armed breakpoint |
| hit_idx | output | IDX_W | Index of the lowest matching breakpoint |

## Verification
Several properties are checked on every cycle: that each repaired mask is contiguous, that a reported hit lies inside the region of the reported breakpoint and respects its load or store enable, that no lower-indexed breakpoint also matched, and that an idle access port keeps `hit` low. Other behaviours show only through the bench's scenarios. These are the exact width of each region at its edges, the particular repair of a broken mask, the disarming of a breakpoint by clearing both enables, and the indifference of matching to the spare control bits. The bench shows each of them by comparing hits against an independent model just inside and just outside each region.

// File: rtl/dbk_pkg.sv
package dbk_pkg;

    localparam int ADDR_W = 32;
    localparam int MASK_W = 6;
    localparam int LD_BIT = 30;
    localparam int ST_BIT = 31;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              ld_en;
        logic              st_en;
        logic [MASK_W-1:0] field;
    } bp_cfg_t;

    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_t;

    // Keep only the run of ones that starts at the top bit of the field.
    function automatic logic [MASK_W-1:0] keep_leading_ones(input logic [MASK_W-1:0] f);
        logic [MASK_W-1:0] r;
        logic              run;
        run = 1'b1;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            run  = run & f[i];
            r[i] = run;
        end
        return r;
    endfunction

    // Ones above the field, field bits below.
    function automatic logic [ADDR_W-1:0] widen_mask(input logic [MASK_W-1:0] f);
        return {{(ADDR_W-MASK_W){1'b1}}, f};
    endfunction

endpackage

// File: rtl/dbk_cfg_regs.sv
module dbk_cfg_regs
    import dbk_pkg::*;
#(
    parameter int NUM_BP = 2,
    parameter int IDX_W  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              sel_ctrl,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] wdata,
    output bp_cfg_t           cfg_q [NUM_BP]
);

    for (genvar g = 0; g < NUM_BP; g++) begin : g_entry
        logic sel;
        assign sel = we && (idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
            end else if (sel) begin
                if (sel_ctrl) begin
                    cfg_q[g].ld_en <= wdata[LD_BIT];
                    cfg_q[g].st_en <= wdata[ST_BIT];
                    cfg_q[g].field <= wdata[MASK_W-1:0];
                end else begin
                    cfg_q[g].addr  <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/dbk_mask_fix.sv
module dbk_mask_fix
    import dbk_pkg::*;
#(
    parameter bit REPAIR = 1'b1
) (
    input  logic [MASK_W-1:0] field,
    output logic [ADDR_W-1:0] mask
);

    if (REPAIR) begin : g_repair
        assign mask = widen_mask(keep_leading_ones(field));
    end else begin : g_raw
        assign mask = widen_mask(field);
    end

endmodule

// File: rtl/dbk_cmp.sv
module dbk_cmp
    import dbk_pkg::*;
(
    input  bp_cfg_t           cfg,
    input  logic [ADDR_W-1:0] mask,
    input  logic [ADDR_W-1:0] acc_addr,
    input  acc_kind_t         kind,
    output logic              match
);

    logic armed;
    logic same_block;

    always_comb begin
        unique case (kind)
            ACC_STORE: armed = cfg.st_en;
            default:   armed = cfg.ld_en;
        endcase
        same_block = ((acc_addr ^ cfg.addr) & mask) == '0;
        match      = armed && same_block;
    end

endmodule

// File: rtl/dbk_prio.sv
module dbk_prio #(
    parameter int N     = 2,
    parameter int IDX_W = 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/dbk_unit.sv
module dbk_unit
    import dbk_pkg::*;
#(
    parameter int NUM_BP = 2,
    parameter bit REPAIR = 1'b1,
    localparam int IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel_ctrl,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_is_store,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);

    bp_cfg_t           cfg_q    [NUM_BP];
    logic [ADDR_W-1:0] eff_mask [NUM_BP];
    logic [NUM_BP-1:0] match_vec;
    logic              any_match;
    logic [IDX_W-1:0]  first_idx;
    acc_kind_t         kind;

    assign kind = acc_is_store ? ACC_STORE : ACC_LOAD;

    dbk_cfg_regs #(.NUM_BP(NUM_BP), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .sel_ctrl (cfg_sel_ctrl),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .cfg_q    (cfg_q)
    );

    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        dbk_mask_fix #(.REPAIR(REPAIR)) u_fix (
            .field (cfg_q[g].field),
            .mask  (eff_mask[g])
        );

        dbk_cmp u_cmp (
            .cfg      (cfg_q[g]),
            .mask     (eff_mask[g]),
            .acc_addr (acc_addr),
            .kind     (kind),
            .match    (match_vec[g])
        );
    end

    dbk_prio #(.N(NUM_BP), .IDX_W(IDX_W)) u_prio (
        .req (match_vec),
        .any (any_match),
        .idx (first_idx)
    );

    assign hit     = acc_valid && any_match;
    assign hit_idx = hit ? first_idx : '0;

endmodule

// File: rtl/dbk_unit_chk.sv
module dbk_unit_chk
    import dbk_pkg::*;
#(
    parameter int NUM_BP = 2,
    parameter int IDX_W  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel_ctrl,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_is_store,
    input  logic              hit,
    input  logic [IDX_W-1:0]  hit_idx,
    input  bp_cfg_t           cfg_q    [NUM_BP],
    input  logic [ADDR_W-1:0] eff_mask [NUM_BP],
    input  logic [NUM_BP-1:0] match_vec
);

    logic [NUM_BP-1:0] below_idx;
    always_comb begin
        for (int k = 0; k < NUM_BP; k++) below_idx[k] = (k < int'(hit_idx));
    end

    for (genvar g = 0; g < NUM_BP; g++) begin : g_chk
        AST_RESET_DISARMS: assert property (@(posedge clk)
            rst |=> (!cfg_q[g].st_en && !cfg_q[g].ld_en)); // R1

        AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (rst)
            (((~eff_mask[g]) + 1'b1) & (~eff_mask[g])) == '0); // R5
    end

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel_ctrl) |=>
            (cfg_q[$past(cfg_idx)].st_en == $past(cfg_wdata[ST_BIT]) &&
             cfg_q[$past(cfg_idx)].ld_en == $past(cfg_wdata[LD_BIT]))); // R2

    AST_ADDR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_sel_ctrl) |=> cfg_q[$past(cfg_idx)].addr == $past(cfg_wdata)); // R2

    AST_KIND_ENABLE: assert property (@(posedge clk) disable iff (rst)
        hit |-> (acc_is_store ? cfg_q[hit_idx].st_en : cfg_q[hit_idx].ld_en)); // R3

    AST_IN_REGION: assert property (@(posedge clk) disable iff (rst)
        hit |-> (((acc_addr ^ cfg_q[hit_idx].addr) & eff_mask[hit_idx]) == '0)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !hit); // R6

    AST_MATCH_REPORTED: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (match_vec != '0)) |-> hit); // R6

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
        hit |-> (match_vec[hit_idx] && ((match_vec & below_idx) == '0))); // R7

    AST_IDX_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_idx == '0)); // R7

endmodule

bind dbk_unit dbk_unit_chk #(.NUM_BP(NUM_BP), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_sel_ctrl (cfg_sel_ctrl),
    .cfg_idx      (cfg_idx),
    .cfg_wdata    (cfg_wdata),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .acc_is_store (acc_is_store),
    .hit          (hit),
    .hit_idx      (hit_idx),
    .cfg_q        (cfg_q),
    .eff_mask     (eff_mask),
    .match_vec    (match_vec)
);

// File: tb/dbk_unit_test.sv
`timescale 1ns/1ps
module dbk_unit_test;

    localparam int NBP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel_ctrl = 1'b0;
    logic [0:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_is_store = 1'b0;
    logic        hit;
    logic [0:0]  hit_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dbk_unit #(.NUM_BP(NBP)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel_ctrl(cfg_sel_ctrl),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_is_store(acc_is_store),
        .hit(hit), .hit_idx(hit_idx)
    );

    typedef struct {
        bit    exp_hit;
        int    exp_idx;
        string req;
    } item_t;

    item_t       sb [$];
    logic [31:0] m_addr [NBP];
    logic [31:0] m_ctrl [NBP];

    // Model: count leading ones of the field, ignore the remaining low bits.
    function automatic bit model_hit(int i, logic [31:0] a, bit st);
        int  n;
        int  low;
        bit  en;
        en = st ? m_ctrl[i][31] : m_ctrl[i][30];
        if (!en) return 1'b0;
        n = 0;
        while (n < 6 && m_ctrl[i][5-n]) n++;
        low = 6 - n;
        return (a >> low) == (m_addr[i] >> low);
    endfunction

    task automatic wr(int i, bit ctrl, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel_ctrl = ctrl; cfg_idx = 1'(i); cfg_wdata = d;
        if (ctrl) m_ctrl[i] = d; else m_addr[i] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(bit v, logic [31:0] a, bit st, string req);
        item_t it;
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_is_store = st;
        it.exp_hit = 1'b0; it.exp_idx = 0; it.req = req;
        if (v) begin
            for (int i = NBP - 1; i >= 0; i--) begin
                if (model_hit(i, a, st)) begin
                    it.exp_hit = 1'b1; it.exp_idx = i;
                end
            end
        end
        sb.push_back(it);
    endtask

    // Monitor: pops one expectation per presented access.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_cmp++;
                if (hit !== it.exp_hit || (it.exp_hit && int'(hit_idx) != it.exp_idx)) begin
                    n_bad++;
                    $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d",
                             it.req, hit, hit_idx, it.exp_hit, it.exp_idx);
                end
            end
        end
    end

    initial begin
        #1_200_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NBP; i++) begin m_addr[i] = '0; m_ctrl[i] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: after reset nothing is armed
        access(1'b1, 32'h0000_0000, 1'b0, "R1 load at zero");
        access(1'b1, 32'h0000_0000, 1'b1, "R1 store at zero");

        // R4 / R3: store breakpoint on an 8-byte block
        wr(0, 1'b0, 32'h1000_0040);
        wr(0, 1'b1, 32'h8000_0038);
        access(1'b1, 32'h1000_0047, 1'b1, "R4 store at top of 8-byte block");
        access(1'b1, 32'h1000_0048, 1'b1, "R4 store just past block");
        access(1'b1, 32'h1000_003F, 1'b1, "R4 store just below block");
        access(1'b1, 32'h1000_0040, 1'b0, "R3 load on store-only breakpoint");

        // R6: valid low suppresses a matching address
        access(1'b0, 32'h1000_0040, 1'b1, "R6 valid low");

        // R3: load-only exact-byte breakpoint
        wr(1, 1'b0, 32'h2000_0004);
        wr(1, 1'b1, 32'h4000_003F);
        access(1'b1, 32'h2000_0004, 1'b0, "R3 load hits load-only");
        access(1'b1, 32'h2000_0004, 1'b1, "R3 store misses load-only");
        access(1'b1, 32'h2000_0005, 1'b0, "R4 exact mask next byte");

        // R5: 6'b110100 repaired to 6'b110000
        wr(1, 1'b0, 32'h3000_0000);
        wr(1, 1'b1, 32'h4000_0034);
        access(1'b1, 32'h3000_000F, 1'b0, "R5 repaired 16-byte top");
        access(1'b1, 32'h3000_0010, 1'b0, "R5 repaired 16-byte past");

        // R5: 6'b011111 repaired to 6'b000000
        wr(1, 1'b0, 32'h4000_0000);
        wr(1, 1'b1, 32'h4000_001F);
        access(1'b1, 32'h4000_003F, 1'b0, "R5 repaired 64-byte top");
        access(1'b1, 32'h4000_0040, 1'b0, "R5 repaired 64-byte past");

        // R7: both match, lowest wins
        wr(0, 1'b0, 32'h4000_0010);
        wr(0, 1'b1, 32'hC000_0000);
        access(1'b1, 32'h4000_0020, 1'b0, "R7 two matches report lowest");
        access(1'b1, 32'h4000_0021, 1'b1, "R3 both enables store");
        // R3: disarm breakpoint 0 while leaving spare bits and mask set
        wr(0, 1'b1, 32'h0000_0FFF);
        access(1'b1, 32'h4000_0020, 1'b0, "R3 disarmed falls to index 1");
        access(1'b1, 32'h4000_0010, 1'b1, "R3 disarmed store no hit");

        // R2: spare control bits set, store-only, exact byte
        wr(0, 1'b0, 32'h6000_0010);
        wr(0, 1'b1, 32'hBFFF_FFFF);
        access(1'b1, 32'h6000_0010, 1'b1, "R2 spare bits store hit");
        access(1'b1, 32'h6000_0010, 1'b0, "R2 spare bits do not enable load");
        access(1'b1, 32'h6000_0011, 1'b1, "R2 spare bits do not widen mask");

        @(negedge clk);
        acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule